// File: doc/BRIEF.md
# Dynamic On-Die Termination Sequencer

This block runs on the memory clock of a DDR3-style DRAM and decides, one cycle at a time, which termination setting the device drives: none, the nominal strength, or the stronger write strength. Every clock edge it samples the external termination-enable pin and the registered write strobe, along with that write's burst kind (chopped to four beats or full eight). Each sampled event is delayed by the same latency, the write latency less two, before it acts on the selector.

A registered write switches the selector to write strength for a fixed window. The window is four cycles for a chopped burst and six for a full burst. After the window the selector falls back to whatever the termination-enable pin called for at that point. Write strength is applied even when the enable pin is low. Alongside the selector, the block watches the enable pin for minimum-high-time violations. A violation sets a sticky flag and captures the cycle index at which it happened. A one-cycle marker shows when the selector has just made a transition whose physical change would land half a clock later. That half-clock offset is reported through the marker only and is not modelled.

The write latency is a run-time input. It must stay constant between resets.

Top module: `dyn_odt_ctrl`

## Requirements
- R1: Synchronous reset (active high) drives the selector to off (code 0), clears the marker, the violation flag and all delayed events. Events sampled before reset never reach the selector.
- R2: When the enable pin is sampled high at edge n, the selector reads nominal (code 1) after edge n+WL-2, provided no write window covers that edge.
- R3: When the enable pin is sampled low at edge n, the selector reads off (code 0) after edge n+WL-2, provided no write window covers that edge.
- R4: A write sampled at edge n makes the selector read write strength (code 2) after edge n+WL-2.
- R5: For a chopped write (burst-kind input 1), the selector reads write strength for exactly 4 edges. It leaves that code after edge n+WL-2+4.
- R6: For a full write (burst-kind input 0), the selector reads write strength for exactly 6 edges. It leaves that code after edge n+WL-2+6.
- R7: A write sampled while the enable pin is low still produces its full write-strength window. The selector then returns to off.
- R8: Write strength wins over nominal, and nominal wins over off. Overlapping write windows combine as their union.
- R9: If the enable pin is sampled low while the required high time is still running, the violation output rises and stays high until reset. The violation cycle output then holds the number of non-reset edges that came before the violating edge. A rising enable requires 4 consecutive high samples, the rising one included.
- R10: A write sampled with the enable pin high extends the required high run. The run must reach 4 samples (chopped) or 6 samples (full), counted from and including the write edge.
- R11: The marker output is high for the one cycle after an edge at which the selector changed value. The exception is a change from off to nominal, which leaves the marker low.
- R12: Every latency above follows the write-latency input over its whole range of 5 to 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous reset, active high |
| wl | input | 5 | Write latency in cycles, 5 to 16 |
| odt_in | input | 1 | Termination-enable pin as registered each edge |
| wr_cmd | input | 1 | Write command registered this edge |
| wr_bc4 | input | 1 | Burst kind of the write: 1 = chop to 4, 0 = full 8 |
| rtt_sel | output | 2 | Termination selector: 0 off, 1 nominal, 2 write strength |
| rtt_half_flag | output | 1 | Selector just made a half-clock-offset transition |
| odt_viol | output | 1 | Sticky minimum-high-time violation |
| viol_cycle | output | 16 | Edge index of the latest violation |

## Verification
On every cycle, the assertions check three things. First, the selector follows the priority order given by the delayed enable level and the write-window state. Second, the write window only counts down by one and never exceeds its longest span. Third, the violation flag never falls and the captured index only moves when the pin is sampled low. Only the bench scenarios can show that the end-to-end latencies come out right. These include the exact window lengths for both burst kinds, correct behaviour at the extreme latency settings, and a violation index that matches the offending edge. They also include the cases where a violation must not fire, because these depend on whole input histories rather than on adjacent cycles.

// File: rtl/dodt_pkg.sv
package dodt_pkg;

   typedef enum logic [1:0] {
      RTT_OFF = 2'd0,
      RTT_NOM = 2'd1,
      RTT_WR  = 2'd2
   } rtt_sel_e;

   // write-strength window lengths per burst kind
   localparam int unsigned SPAN_CHOP = 4;
   localparam int unsigned SPAN_FULL = 6;
   // minimum consecutive high samples after a rising enable
   localparam int unsigned MIN_HIGH  = 4;
   // counter width able to hold the longest span minus one
   localparam int unsigned SPAN_W    = 3;

endpackage

// File: rtl/odt_lat_pipe.sv
module odt_lat_pipe #(
   parameter int unsigned W     = 3,
   parameter int unsigned DEPTH = 14,
   parameter int unsigned IDX_W = 5
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [W-1:0]     din,
   input  logic [IDX_W-1:0] tap_idx,
   output logic [W-1:0]     tap
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("odt_lat_pipe: DEPTH must be at least 2");
   end
   if ((1 << IDX_W) < DEPTH) begin : g_bad_idx
      $error("odt_lat_pipe: IDX_W too narrow for DEPTH");
   end

   logic [DEPTH-1:0][W-1:0] stg;
   logic [DEPTH-1:0][W-1:0] masked;

   always_ff @(posedge clk) begin
      if (rst) stg <= '0;
      else     stg <= {stg[DEPTH-2:0], din};
   end

   // one-hot AND-OR tap selection, one slice per stage
   for (genvar g = 0; g < DEPTH; g++) begin : g_tap
      assign masked[g] = (tap_idx == IDX_W'(g)) ? stg[g] : '0;
   end

   always_comb begin
      tap = '0;
      for (int i = 0; i < DEPTH; i++) tap = tap | masked[i];
   end

   // R12: the requested offset must exist in the pipeline
   p_tap_range_r12: assert property (@(posedge clk) disable iff (rst)
      tap_idx < IDX_W'(DEPTH));

endmodule

// File: rtl/odt_wr_window.sv
module odt_wr_window
   import dodt_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic arrive,
   input  logic chop,
   output logic active
);

   logic [SPAN_W-1:0] left_q;
   logic [SPAN_W-1:0] load_v;
   logic [SPAN_W-1:0] dec_v;
   logic [SPAN_W-1:0] left_n;

   always_comb begin
      if (!arrive)  load_v = '0;
      else if (chop) load_v = SPAN_W'(SPAN_CHOP - 1);
      else          load_v = SPAN_W'(SPAN_FULL - 1);
      dec_v  = (left_q != '0) ? left_q - 1'b1 : '0;
      // union of overlapping windows: keep the later end
      left_n = (load_v > dec_v) ? load_v : dec_v;
      active = arrive || (left_q != '0);
   end

   always_ff @(posedge clk) begin
      if (rst) left_q <= '0;
      else     left_q <= left_n;
   end

   // R6: remaining window never exceeds the longest span
   p_span_cap_r6: assert property (@(posedge clk) disable iff (rst)
      left_q <= SPAN_W'(SPAN_FULL - 1));

   // R5: without a new write the window drains one per cycle
   p_drain_r5: assert property (@(posedge clk) disable iff (rst)
      (left_q != '0 && !arrive) |=> (left_q == $past(left_q) - 1'b1));

endmodule

// File: rtl/odt_hold_mon.sv
module odt_hold_mon
   import dodt_pkg::*;
#(
   parameter int unsigned CYC_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             odt_in,
   input  logic             wr_cmd,
   input  logic             wr_chop,
   output logic             viol,
   output logic [CYC_W-1:0] viol_cycle
);

   if (CYC_W < 4) begin : g_bad_cyc
      $error("odt_hold_mon: CYC_W too small");
   end

   logic             odt_prev_q;
   logic [SPAN_W-1:0] rem_q;
   logic [SPAN_W-1:0] rem_n;
   logic [SPAN_W-1:0] req_v;
   logic [SPAN_W-1:0] start_v;
   logic             hit_v;
   logic [CYC_W-1:0] cyc_q;

   always_comb begin
      if (!wr_cmd)     req_v = '0;
      else if (wr_chop) req_v = SPAN_W'(SPAN_CHOP - 1);
      else             req_v = SPAN_W'(SPAN_FULL - 1);
      if (!odt_prev_q)        start_v = SPAN_W'(MIN_HIGH - 1);
      else if (rem_q != '0)   start_v = rem_q - 1'b1;
      else                    start_v = '0;
      hit_v = !odt_in && (rem_q != '0);
      if (odt_in) rem_n = (req_v > start_v) ? req_v : start_v;
      else        rem_n = '0;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         odt_prev_q <= 1'b0;
         rem_q      <= '0;
         cyc_q      <= '0;
         viol       <= 1'b0;
         viol_cycle <= '0;
      end else begin
         odt_prev_q <= odt_in;
         rem_q      <= rem_n;
         cyc_q      <= cyc_q + 1'b1;
         if (hit_v) begin
            viol       <= 1'b1;
            viol_cycle <= cyc_q;
         end
      end
   end

   // R9: violation is sticky until reset
   p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
      viol |=> viol);

   // R9: captured index only moves on a low sample
   p_capture_r9: assert property (@(posedge clk) disable iff (rst)
      odt_in |=> $stable(viol_cycle));

   // R10: required run never exceeds the full-burst span
   p_rem_cap_r10: assert property (@(posedge clk) disable iff (rst)
      rem_q <= SPAN_W'(SPAN_FULL - 1));

endmodule

// File: rtl/dyn_odt_ctrl.sv
module dyn_odt_ctrl
   import dodt_pkg::*;
#(
   parameter int unsigned WL_MIN = 5,
   parameter int unsigned WL_MAX = 16,
   parameter int unsigned CYC_W  = 16,
   localparam int unsigned WL_W  = $clog2(WL_MAX + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WL_W-1:0]  wl,
   input  logic             odt_in,
   input  logic             wr_cmd,
   input  logic             wr_bc4,
   output logic [1:0]       rtt_sel,
   output logic             rtt_half_flag,
   output logic             odt_viol,
   output logic [CYC_W-1:0] viol_cycle
);

   localparam int unsigned DEPTH = WL_MAX - 2;
   localparam int unsigned EV_W  = 3;

   if (WL_MIN < 5) begin : g_bad_min
      $error("dyn_odt_ctrl: WL_MIN below 5 leaves too few pipeline stages");
   end
   if (WL_MAX < WL_MIN) begin : g_bad_range
      $error("dyn_odt_ctrl: WL_MAX below WL_MIN");
   end

   logic [EV_W-1:0] ev_in;
   logic [EV_W-1:0] ev_tap;
   logic [WL_W-1:0] tap_idx;
   logic            wr_arr;
   logic            chop_arr;
   logic            odt_arr;
   logic            wr_act;
   rtt_sel_e        sel_q;
   rtt_sel_e        sel_n;
   logic            flag_q;
   logic            flag_n;

   assign ev_in   = {wr_cmd, wr_bc4, odt_in};
   // event sampled at edge n must act at edge n+WL-2: tap index WL-3
   assign tap_idx = wl - WL_W'(3);
   assign {wr_arr, chop_arr, odt_arr} = ev_tap;

   odt_lat_pipe #(
      .W     (EV_W),
      .DEPTH (DEPTH),
      .IDX_W (WL_W)
   ) u_pipe (
      .clk     (clk),
      .rst     (rst),
      .din     (ev_in),
      .tap_idx (tap_idx),
      .tap     (ev_tap)
   );

   odt_wr_window u_win (
      .clk    (clk),
      .rst    (rst),
      .arrive (wr_arr),
      .chop   (chop_arr),
      .active (wr_act)
   );

   odt_hold_mon #(
      .CYC_W (CYC_W)
   ) u_hold (
      .clk        (clk),
      .rst        (rst),
      .odt_in     (odt_in),
      .wr_cmd     (wr_cmd),
      .wr_chop    (wr_bc4),
      .viol       (odt_viol),
      .viol_cycle (viol_cycle)
   );

   always_comb begin
      if (wr_act)       sel_n = RTT_WR;
      else if (odt_arr) sel_n = RTT_NOM;
      else              sel_n = RTT_OFF;
      flag_n = (sel_n != sel_q) && !(sel_q == RTT_OFF && sel_n == RTT_NOM);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         sel_q  <= RTT_OFF;
         flag_q <= 1'b0;
      end else begin
         sel_q  <= sel_n;
         flag_q <= flag_n;
      end
   end

   assign rtt_sel       = sel_q;
   assign rtt_half_flag = flag_q;

   // R1: reset forces the selector off and the marker low
   p_reset_off_r1: assert property (@(posedge clk)
      rst |=> (rtt_sel == 2'd0 && !rtt_half_flag));

   // R8: an open write window wins over any delayed level
   p_wr_prio_r8: assert property (@(posedge clk) disable iff (rst)
      wr_act |=> (rtt_sel == 2'd2));

   // R2: delayed high level without a window gives nominal
   p_nom_follow_r2: assert property (@(posedge clk) disable iff (rst)
      (!wr_act && odt_arr) |=> (rtt_sel == 2'd1));

   // R3: delayed low level without a window gives off
   p_off_follow_r3: assert property (@(posedge clk) disable iff (rst)
      (!wr_act && !odt_arr) |=> (rtt_sel == 2'd0));

   // R11: marker only follows an actual change, never off to nominal
   p_flag_change_r11: assert property (@(posedge clk) disable iff (rst)
      rtt_half_flag |-> (rtt_sel != $past(rtt_sel)) &&
                        !($past(rtt_sel) == 2'd0 && rtt_sel == 2'd1));

   // R12: write latency stays within the supported range
   p_wl_range_r12: assert property (@(posedge clk) disable iff (rst)
      (wl >= WL_W'(WL_MIN)) && (wl <= WL_W'(WL_MAX)));

endmodule

// File: tb/dyn_odt_ctrl_tb_top.sv
module dyn_odt_ctrl_tb_top;

   typedef struct {
      int         idx;
      logic [1:0] sel;
      logic       flag;
      string      tag;
   } item_t;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [4:0]  wl = 5'd9;
   logic        odt_in = 1'b0;
   logic        wr_cmd = 1'b0;
   logic        wr_bc4 = 1'b0;
   logic [1:0]  rtt_sel;
   logic        rtt_half_flag;
   logic        odt_viol;
   logic [15:0] viol_cycle;

   int    n_chk = 0;
   int    n_bad = 0;
   int    n = 0;
   int    lat = 7;
   bit    done = 1'b0;
   string cur = "R1";
   logic [1:0] prev_exp = 2'd0;
   bit    nom_arr [512];
   bit    wr_arr  [512];
   item_t sb_q [$];

   always #5 clk = ~clk;

   dyn_odt_ctrl dut_i (
      .clk           (clk),
      .rst           (rst),
      .wl            (wl),
      .odt_in        (odt_in),
      .wr_cmd        (wr_cmd),
      .wr_bc4        (wr_bc4),
      .rtt_sel       (rtt_sel),
      .rtt_half_flag (rtt_half_flag),
      .odt_viol      (odt_viol),
      .viol_cycle    (viol_cycle)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   // driver: called at a negedge, covers exactly one posedge
   task automatic step(input logic o, input logic w, input logic b);
      item_t it;
      logic [1:0] e;
      int span;
      odt_in = o;
      wr_cmd = w;
      wr_bc4 = b;
      nom_arr[n + lat] = o;
      if (w) begin
         span = b ? 4 : 6;
         for (int j = 0; j < span; j++) wr_arr[n + lat + j] = 1'b1;
      end
      e = wr_arr[n] ? 2'd2 : (nom_arr[n] ? 2'd1 : 2'd0);
      it.idx  = n;
      it.sel  = e;
      it.flag = (e != prev_exp) && !(prev_exp == 2'd0 && e == 2'd1);
      it.tag  = cur;
      prev_exp = e;
      sb_q.push_back(it);
      n++;
      @(negedge clk);
   endtask

   task automatic idle(input int k);
      for (int i = 0; i < k; i++) step(1'b0, 1'b0, 1'b0);
   endtask

   task automatic high(input int k);
      for (int i = 0; i < k; i++) step(1'b1, 1'b0, 1'b0);
   endtask

   task automatic do_reset(input logic [4:0] wl_v);
      @(negedge clk);
      rst = 1'b1;
      odt_in = 1'b0;
      wr_cmd = 1'b0;
      wr_bc4 = 1'b0;
      wl = wl_v;
      repeat (2) @(negedge clk);
      // R1: reset state
      check("R1 sel", rtt_sel, 0);
      check("R1 flag", rtt_half_flag, 0);
      check("R1 viol", odt_viol, 0);
      for (int i = 0; i < 512; i++) begin
         nom_arr[i] = 1'b0;
         wr_arr[i]  = 1'b0;
      end
      n = 0;
      lat = int'(wl_v) - 2;
      prev_exp = 2'd0;
      sb_q.delete();
      rst = 1'b0;
   endtask

   // monitor: pops one expectation per non-reset edge
   always @(posedge clk) begin
      #2;
      if (!rst && sb_q.size() > 0) begin
         item_t it;
         it = sb_q.pop_front();
         check({it.tag, " sel"}, rtt_sel, it.sel);
         check("R11 flag", rtt_half_flag, it.flag);
      end
   end

   initial begin
      int vn;
      // R2/R3 basic latency at WL 9
      do_reset(5'd9);
      cur = "R2"; high(6);
      cur = "R3"; idle(12);
      check("R9 no viol", odt_viol, 0);
      // R4/R6 full write with enable high
      cur = "R6"; high(2); step(1, 1, 0); high(8); idle(14);
      // R5 chopped write at the rising edge
      cur = "R5"; step(1, 1, 1); high(5); idle(14);
      // R7 writes with enable low
      cur = "R7"; step(0, 1, 0); idle(4); step(0, 1, 1); idle(14);
      // R8 two full writes four apart, and overlapping windows
      cur = "R8"; step(1, 1, 0); high(3); step(1, 1, 0); high(8); idle(14);
      step(0, 1, 0); step(0, 1, 1); idle(14);
      check("R10 no viol", odt_viol, 0);
      // R1 reset while events are pending
      cur = "R1"; step(1, 1, 0); high(3);
      do_reset(5'd9);
      idle(14);
      // R12 extreme latencies
      do_reset(5'd5);
      cur = "R12"; high(4); idle(3); step(1, 1, 1); high(3); step(0, 1, 0); idle(10);
      do_reset(5'd16);
      cur = "R12"; high(5); idle(2); step(1, 1, 0); high(5); idle(4); step(0, 1, 1); idle(20);
      check("R12 no viol", odt_viol, 0);
      // R9 short pulse
      do_reset(5'd9);
      cur = "R9"; idle(3); high(2); vn = n; step(0, 0, 0); idle(10);
      check("R9 viol", odt_viol, 1);
      check("R9 cycle", viol_cycle, vn);
      high(6); idle(10);
      check("R9 sticky", odt_viol, 1);
      check("R9 cycle kept", viol_cycle, vn);
      // R10 full write at rise needs six highs
      do_reset(5'd9);
      cur = "R10"; step(1, 1, 0); high(5); idle(12);
      check("R10 six ok", odt_viol, 0);
      step(1, 1, 0); high(3); vn = n; step(0, 0, 0); idle(12);
      check("R10 full viol", odt_viol, 1);
      check("R10 full cycle", viol_cycle, vn);
      // R10 chopped write on second high sample extends run
      do_reset(5'd9);
      cur = "R10"; idle(2); step(1, 0, 0); step(1, 1, 1); high(2); vn = n; step(0, 0, 0); idle(12);
      check("R10 chop viol", odt_viol, 1);
      check("R10 chop cycle", viol_cycle, vn);
      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #2000000;
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule